// File: doc/BRIEF.md
# Signed Format Conversion Chain

This block is a combinational datapath made of three stages in series. The first stage reads a small sign-magnitude code and turns it into two's complement. The second stage computes twice that value minus one, in a result one bit wider. The third stage turns that result back into a magnitude and a separate sign flag.

The third stage negates the value with an invert-and-increment chain of half adders. A two-way multiplexer, steered by the result's sign bit, then picks either the value or its negation. Each bus between stages is also an output, so a designer can see what every stage produces.

All widths follow one parameter, the magnitude width (default 2). The input code is then 3 bits, the doubled result 4 bits and the output magnitude 3 bits. Every input magnitude is at most 3, so every input code lies inside the range where the doubling stage is defined.

Top module: `sfc_chain`

## Requirements
- R1: `in_code[2]` is the sign (1 = negative) and `in_code[1:0]` is the magnitude. `a_out` is the 3-bit two's complement form of that value.
- R2: The negative-zero code 3'b100 gives `a_out` = 3'b000, the same as positive zero.
- R3: `b_out` is the 4-bit two's complement encoding of 2*A - 1, where A is the signed value of `a_out`.
- R4: `b_out[0]` is 1 for every input code.
- R5: `d_neg` equals `b_out[3]`, so it is 1 exactly when the doubled result is negative.
- R6: `d_mag` is the absolute value of the signed value of `b_out`, as a 3-bit unsigned number. Its range is 1 to 7.
- R7: Both zero codes (3'b000 and 3'b100) give `d_mag` = 3'b001 with `d_neg` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_code | input | 3 | Sign-magnitude input, sign in the top bit |
| a_out | output | 3 | Two's complement form of the input |
| b_out | output | 4 | Two's complement value 2*A - 1 |
| d_mag | output | 3 | Unsigned magnitude of b_out |
| d_neg | output | 1 | Sign of b_out, 1 when negative |

## Verification
The block has no registers, so every output is due in the same cycle as the input that causes it. No result lags its stimulus by any number of clock edges. The bench changes `in_code` just after a rising edge and reads all four outputs at the next falling edge, half a period later. This leaves the settling time of the three stages inside one half period. The bench sweeps all eight codes in two orders. It compares each output against values worked out with integer arithmetic in the bench.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  // magnitude bits of the sign-magnitude input
  localparam int SFC_MAG_W = 2;
endpackage

// File: rtl/sfc_smag_to_twos.sv
module sfc_smag_to_twos #(
  parameter int MAG_W = sfc_pkg::SFC_MAG_W
) (
  input  logic [MAG_W:0] smag,
  output logic [MAG_W:0] twos
);
  localparam int AW = MAG_W + 1;
  logic              neg;
  logic [MAG_W-1:0]  mag;
  logic [AW-1:0]     mag_ext;

  assign neg     = smag[MAG_W];
  assign mag     = smag[MAG_W-1:0];
  assign mag_ext = {1'b0, mag};
  assign twos    = neg ? (~mag_ext + AW'(1)) : mag_ext;

  always_comb begin
    if (!$isunknown(smag)) begin
      AST_SIGN_FOLLOWS: assert ((mag == '0) || (twos[AW-1] == neg)); // R1
      AST_ZERO_FOLDS: assert ((mag != '0) || (twos == '0)); // R2
      AST_ADDS_TO_ZERO: assert (!neg || (AW'(twos + mag_ext) == '0)); // R1
    end
  end
endmodule

// File: rtl/sfc_double_dec.sv
module sfc_double_dec #(
  parameter int MAG_W = sfc_pkg::SFC_MAG_W
) (
  input  logic [MAG_W:0]   a_in,
  output logic [MAG_W+1:0] b_res
);
  localparam int BW = MAG_W + 2;

  assign b_res = {a_in, 1'b0} - BW'(1);

  always_comb begin
    if (!$isunknown(a_in)) begin
      AST_RESULT_ODD: assert (b_res[0] == 1'b1); // R4
      AST_SIGN_RULE: assert (b_res[BW-1] == (a_in[MAG_W] || (a_in == '0))); // R3
    end
  end
endmodule

// File: rtl/sfc_negate.sv
module sfc_negate #(
  parameter int W = sfc_pkg::SFC_MAG_W + 2
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] neg_val
);
  logic [W-1:0] inv;
  logic [W:0]   carry;

  assign inv      = ~val;
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_half_add
    assign neg_val[i]  = inv[i] ^ carry[i];
    assign carry[i+1]  = inv[i] & carry[i];
  end

  always_comb begin
    if (!$isunknown(val)) begin
      AST_NEG_CANCELS: assert (W'(val + neg_val) == '0); // R6
    end
  end
endmodule

// File: rtl/sfc_twos_to_smag.sv
module sfc_twos_to_smag #(
  parameter int MAG_W = sfc_pkg::SFC_MAG_W
) (
  input  logic [MAG_W+1:0] b_in,
  output logic [MAG_W:0]   mag_out,
  output logic             sign_out
);
  localparam int BW = MAG_W + 2;
  logic [BW-1:0] b_neg;
  logic [BW-1:0] picked;

  sfc_negate #(.W(BW)) u_neg (
    .val     (b_in),
    .neg_val (b_neg)
  );

  assign sign_out = b_in[BW-1];
  assign picked   = sign_out ? b_neg : b_in;
  assign mag_out  = picked[MAG_W:0];

  always_comb begin
    if (!$isunknown(b_in)) begin
      AST_PICK_NONNEG: assert (picked[BW-1] == 1'b0 || b_in[BW-2:0] == '0); // R6
      AST_MAG_NONZERO: assert (!b_in[0] || (mag_out != '0)); // R6
    end
  end
endmodule

// File: rtl/sfc_chain.sv
module sfc_chain #(
  parameter int MAG_W = sfc_pkg::SFC_MAG_W
) (
  input  logic [MAG_W:0]   in_code,
  output logic [MAG_W:0]   a_out,
  output logic [MAG_W+1:0] b_out,
  output logic [MAG_W:0]   d_mag,
  output logic             d_neg
);
  sfc_smag_to_twos #(.MAG_W(MAG_W)) u_stage1 (
    .smag (in_code),
    .twos (a_out)
  );

  sfc_double_dec #(.MAG_W(MAG_W)) u_stage2 (
    .a_in  (a_out),
    .b_res (b_out)
  );

  sfc_twos_to_smag #(.MAG_W(MAG_W)) u_stage3 (
    .b_in     (b_out),
    .mag_out  (d_mag),
    .sign_out (d_neg)
  );

  always_comb begin
    if (!$isunknown(in_code)) begin
      AST_SIGN_END: assert (d_neg == (in_code[MAG_W] || (in_code[MAG_W-1:0] == '0))); // R5
      AST_ZERO_END: assert ((in_code[MAG_W-1:0] != '0) || (d_mag == 1 && d_neg)); // R7
    end
  end
endmodule

// File: tb/sfc_chain_test.sv
module sfc_chain_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] in_code = 3'b000;
  logic [2:0] a_out;
  logic [3:0] b_out;
  logic [2:0] d_mag;
  logic       d_neg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sfc_chain uut (
    .in_code (in_code),
    .a_out   (a_out),
    .b_out   (b_out),
    .d_mag   (d_mag),
    .d_neg   (d_neg)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s code=%b actual=%0d expected=%0d", req, in_code, act, exp);
    end
  endtask

  task automatic check_code(input logic [2:0] code);
    int val, b, d;
    @(posedge clk);
    #1 in_code = code;
    @(negedge clk);
    val = code[2] ? -int'(code[1:0]) : int'(code[1:0]);
    b = 2 * val - 1;
    d = (b < 0) ? -b : b;
    chk(code == 3'b100 ? "R2" : "R1", int'(a_out), val & 7);
    chk("R3", int'(b_out), b & 15);
    chk("R4", int'(b_out[0]), 1);
    chk("R5", int'(d_neg), (b < 0) ? 1 : 0);
    chk(code[1:0] == 2'b00 ? "R7" : "R6", int'(d_mag), d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: input held at 000 gives d_mag 1, negative (R7)
    chk("R7", int'(d_mag), 1);
    chk("R7", int'(d_neg), 1);
    chk("R3", int'(b_out), 15);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) check_code(3'(i));
    for (int i = 7; i >= 0; i--) check_code(3'(i));
    // negative zero against positive zero back to back (R2, R7)
    check_code(3'b100);
    check_code(3'b000);
    check_code(3'b111);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule